// File: doc/BRIEF.md
# Reset Strap and Colour-Bar Test-Pattern Controller

This block sets how a display encoder behaves at power-up and which signals leave through its interrupt pins. While reset is held, it reads the level on the dedicated interrupt pin as a hardware strap. A low level selects a self-test mode. In that mode the block produces a full-amplitude colour-bar pixel stream as soon as reset is released, and no register has to be written. The block then keeps the strap value until the next reset.

The block drives two open-drain outputs. The dedicated interrupt pin always reports pending events. The shared pin reports pending events after reset. When a control bit is set, the shared pin instead carries the internal PLL clock. Event flags are sticky and have a per-event enable. Either interrupt pin pulls low while any enabled flag is set. The outputs are modelled as an output-enable, where enable means "pull low", plus a data value.

Top module: `tpat_strap_ctrl`

## Requirements
- R1: `test_mode_o` is 1 after reset exactly when `ded_pin_i` was 0 on the last rising clock edge with `rst_i` high. The value holds until the next reset, whatever `ded_pin_i` does afterwards. `test_mode_o` is 0 while `rst_i` is high.
- R2: In the cycle after any clock edge with `rst_i` high, `ded_pin_oe` and `shr_pin_oe` are both 0, so the strap pin is not driven.
- R3: An event flag bit is set on a clock edge where its `evt_set_i` bit is 1. It stays set until an edge where its `evt_clr_i` bit is 1 and its set bit is 0. A set and a clear on the same edge leave the flag set.
- R4: A pending interrupt exists when any flag is set and its `evt_en_i` bit is 1. A set flag that is disabled does not pull either pin low. It does pull low as soon as its enable is raised.
- R5: After reset the shared pin is in interrupt mode. `sel_clk_i` is registered. In the cycle after an edge where it is 1, `shr_pin_oe` is 1 and `shr_pin_o` follows `pll_clk_i`. In interrupt mode, `shr_pin_o` is 0 and `shr_pin_oe` is 1 exactly when an interrupt is pending.
- R6: `ded_pin_oe` is 1 exactly when an interrupt is pending, in either shared-pin mode.
- R7: In test mode, `pix_valid_o` is 1 from the first cycle after reset. `pix_x_o` starts at 0, rises by one per clock and wraps to 0 after `line_w_i`-1.
- R8: In test mode, the bar index is `pix_x_o / (line_w_i/8)`, where `line_w_i` is a multiple of 8 and at least 8. The bars, with 8-bit R,G,B values packed into `pix_rgb_o` as {R,G,B}, are in this order:
  - 0 white FF,FF,FF
  - 1 yellow FF,FF,00
  - 2 cyan 00,FF,FF
  - 3 green 00,FF,00
  - 4 magenta FF,00,FF
  - 5 red FF,00,00
  - 6 blue 00,00,FF
  - 7 black 00,00,00
- R9: Outside test mode, `pix_valid_o`, `pix_x_o` and `pix_rgb_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_i | input | 1 | Synchronous active-high reset; strap sampled while high |
| ded_pin_i | input | 1 | Level seen on the dedicated interrupt pin (strap) |
| sel_clk_i | input | 1 | Control bit: 1 puts the PLL clock on the shared pin |
| pll_clk_i | input | 1 | PLL clock routed to the shared pin |
| evt_set_i | input | N_EVT | Event set pulses |
| evt_clr_i | input | N_EVT | Event clear pulses |
| evt_en_i | input | N_EVT | Per-event interrupt enables |
| line_w_i | input | LW_BITS | Active line width in pixels for the bars |
| shr_pin_o | output | 1 | Shared pin data value |
| shr_pin_oe | output | 1 | Shared pin drive enable |
| ded_pin_oe | output | 1 | Dedicated pin pull-low enable |
| test_mode_o | output | 1 | Self-test mode latched from the strap |
| pix_valid_o | output | 1 | Test pixel valid |
| pix_x_o | output | LW_BITS | Horizontal pixel counter |
| pix_rgb_o | output | 24 | Test pixel {R,G,B} |

## Verification
The bench builds the block with N_EVT=3 and LW_BITS=7, so line widths go up to 127. With these values, a full 64-pixel line and its wrap fit in a short run. Narrow lines of 8 pixels, with one pixel per bar, and 16 pixels are also run. The three event bits allow a flag to be tested while disabled and enabled, and for set and clear on the same edge. A scoreboard compares every pixel against bar positions computed from the line width. Strap sampling is tested with both levels, including pin activity after release.

// File: rtl/tpat_pkg.sv
package tpat_pkg;

    localparam int CH_W = 8;

    typedef enum logic [2:0] {
        BAR_WHITE   = 3'd0,
        BAR_YELLOW  = 3'd1,
        BAR_CYAN    = 3'd2,
        BAR_GREEN   = 3'd3,
        BAR_MAGENTA = 3'd4,
        BAR_RED     = 3'd5,
        BAR_BLUE    = 3'd6,
        BAR_BLACK   = 3'd7
    } bar_e;

    typedef enum logic {
        PIN_IRQ = 1'b0,
        PIN_CLK = 1'b1
    } pin_mode_e;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;

    // Full-amplitude primaries: each channel is on or off depending on one index bit.
    function automatic rgb_t bar_colour(bar_e idx);
        rgb_t c;
        c.r = {CH_W{~idx[1]}};
        c.g = {CH_W{~idx[2]}};
        c.b = {CH_W{~idx[0]}};
        return c;
    endfunction

endpackage

// File: rtl/tpat_strap_latch.sv
module tpat_strap_latch (
    input  logic clk_i,
    input  logic rst_i,
    input  logic strap_pin_i,
    output logic test_mode_o
);
    logic strap_q;

    // Tracks the pin during reset; the last reset edge leaves the final value.
    always_ff @(posedge clk_i) begin
        if (rst_i) strap_q <= strap_pin_i;
    end

    assign test_mode_o = ~strap_q & ~rst_i;

    assert_strap_hold_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) |-> $stable(test_mode_o));
endmodule

// File: rtl/tpat_irq_flags.sv
module tpat_irq_flags #(
    parameter int N_EVT = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [N_EVT-1:0] set_i,
    input  logic [N_EVT-1:0] clr_i,
    input  logic [N_EVT-1:0] en_i,
    output logic             pend_o
);
    logic [N_EVT-1:0] flag_q;

    for (genvar i = 0; i < N_EVT; i++) begin : g_flag
        always_ff @(posedge clk_i) begin
            if (rst_i)         flag_q[i] <= 1'b0;
            else if (set_i[i]) flag_q[i] <= 1'b1;
            else if (clr_i[i]) flag_q[i] <= 1'b0;
        end

        assert_set_wins_R3: assert property (@(posedge clk_i) disable iff (rst_i)
            set_i[i] |=> flag_q[i]);
        assert_sticky_R3: assert property (@(posedge clk_i) disable iff (rst_i)
            (flag_q[i] && !clr_i[i]) |=> flag_q[i]);
    end

    assign pend_o = |(flag_q & en_i);
endmodule

// File: rtl/tpat_bar_gen.sv
module tpat_bar_gen
    import tpat_pkg::*;
#(
    parameter int LW_BITS = 12
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               run_i,
    input  logic [LW_BITS-1:0] line_w_i,
    output logic               pix_valid_o,
    output logic [LW_BITS-1:0] pix_x_o,
    output logic [3*CH_W-1:0]  pix_rgb_o
);
    localparam int SEG_BITS = LW_BITS - 3;
    localparam logic [LW_BITS-1:0]  X_ONE   = 1;
    localparam logic [SEG_BITS-1:0] SEG_ONE = 1;

    logic [LW_BITS-1:0]  x_q;
    logic [SEG_BITS-1:0] seg_q;
    logic [2:0]          bar_q;
    logic [SEG_BITS-1:0] seg_w;
    rgb_t                colour;

    assign seg_w = line_w_i[LW_BITS-1:3];

    always_ff @(posedge clk_i) begin
        if (rst_i || !run_i) begin
            x_q   <= '0;
            seg_q <= '0;
            bar_q <= '0;
        end else if (x_q == line_w_i - X_ONE) begin
            x_q   <= '0;
            seg_q <= '0;
            bar_q <= '0;
        end else begin
            x_q <= x_q + X_ONE;
            if (seg_q == seg_w - SEG_ONE) begin
                seg_q <= '0;
                bar_q <= bar_q + 3'd1;
            end else begin
                seg_q <= seg_q + SEG_ONE;
            end
        end
    end

    assign colour      = bar_colour(bar_e'(bar_q));
    assign pix_valid_o = run_i;
    assign pix_x_o     = run_i ? x_q : '0;
    assign pix_rgb_o   = run_i ? colour : '0;

    assert_x_step_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_i && $past(run_i) && !$past(rst_i) && pix_x_o != '0)
            |-> pix_x_o == $past(pix_x_o) + X_ONE);
    assert_x_range_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        run_i |-> pix_x_o < line_w_i);
    assert_line_starts_white_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_i && pix_x_o == '0) |-> pix_rgb_o == {3*CH_W{1'b1}});
endmodule

// File: rtl/tpat_strap_ctrl.sv
module tpat_strap_ctrl
    import tpat_pkg::*;
#(
    parameter int N_EVT   = 4,
    parameter int LW_BITS = 12
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               ded_pin_i,
    input  logic               sel_clk_i,
    input  logic               pll_clk_i,
    input  logic [N_EVT-1:0]   evt_set_i,
    input  logic [N_EVT-1:0]   evt_clr_i,
    input  logic [N_EVT-1:0]   evt_en_i,
    input  logic [LW_BITS-1:0] line_w_i,
    output logic               shr_pin_o,
    output logic               shr_pin_oe,
    output logic               ded_pin_oe,
    output logic               test_mode_o,
    output logic               pix_valid_o,
    output logic [LW_BITS-1:0] pix_x_o,
    output logic [3*CH_W-1:0]  pix_rgb_o
);
    logic      test_mode;
    logic      pend;
    pin_mode_e mode_q;

    tpat_strap_latch u_strap (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .strap_pin_i (ded_pin_i),
        .test_mode_o (test_mode)
    );

    tpat_irq_flags #(.N_EVT(N_EVT)) u_irq (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .set_i  (evt_set_i),
        .clr_i  (evt_clr_i),
        .en_i   (evt_en_i),
        .pend_o (pend)
    );

    tpat_bar_gen #(.LW_BITS(LW_BITS)) u_bars (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .run_i       (test_mode),
        .line_w_i    (line_w_i),
        .pix_valid_o (pix_valid_o),
        .pix_x_o     (pix_x_o),
        .pix_rgb_o   (pix_rgb_o)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) mode_q <= PIN_IRQ;
        else       mode_q <= sel_clk_i ? PIN_CLK : PIN_IRQ;
    end

    // Open-drain interrupt: data is low and the enable pulls the line down.
    always_comb begin
        if (mode_q == PIN_CLK) begin
            shr_pin_o  = pll_clk_i;
            shr_pin_oe = 1'b1;
        end else begin
            shr_pin_o  = 1'b0;
            shr_pin_oe = pend;
        end
    end

    assign ded_pin_oe  = pend;
    assign test_mode_o = test_mode;

    assert_pins_quiet_R2: assert property (@(posedge clk_i)
        $past(rst_i) |-> (!ded_pin_oe && !shr_pin_oe));
    assert_irq_mirror_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(sel_clk_i) && !$past(rst_i)) |-> (shr_pin_oe == ded_pin_oe && !shr_pin_o));
    assert_clk_drive_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(sel_clk_i) && !$past(rst_i)) |-> shr_pin_oe);
    assert_no_pix_idle_R9: assert property (@(posedge clk_i)
        !test_mode_o |-> (!pix_valid_o && pix_rgb_o == '0));
endmodule

// File: tb/sim_tpat_strap_ctrl.sv
module sim_tpat_strap_ctrl;
    localparam int NE = 3;
    localparam int LW = 7;

    logic          clk = 1'b0;
    logic          rst, ded_pin, sel_clk, pll_clk;
    logic [NE-1:0] evt_set, evt_clr, evt_en;
    logic [LW-1:0] line_w;
    logic          shr_o, shr_oe, ded_oe, tmode, pvalid;
    logic [LW-1:0] px;
    logic [23:0]   prgb;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    typedef struct { int x; logic [23:0] rgb; } item_t;
    item_t exp_q[$];

    always #5 clk = ~clk;

    tpat_strap_ctrl #(.N_EVT(NE), .LW_BITS(LW)) u0 (
        .clk_i(clk), .rst_i(rst), .ded_pin_i(ded_pin), .sel_clk_i(sel_clk),
        .pll_clk_i(pll_clk), .evt_set_i(evt_set), .evt_clr_i(evt_clr),
        .evt_en_i(evt_en), .line_w_i(line_w), .shr_pin_o(shr_o),
        .shr_pin_oe(shr_oe), .ded_pin_oe(ded_oe), .test_mode_o(tmode),
        .pix_valid_o(pvalid), .pix_x_o(px), .pix_rgb_o(prgb));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] bar_rgb(int idx);
        case (idx)
            0: return 24'hFFFFFF;
            1: return 24'hFFFF00;
            2: return 24'h00FFFF;
            3: return 24'h00FF00;
            4: return 24'hFF00FF;
            5: return 24'hFF0000;
            6: return 24'h0000FF;
            default: return 24'h000000;
        endcase
    endfunction

    // Driver: expected bar pixels for n cycles of a w-wide line (R7, R8).
    task automatic push_line(input int w, input int n);
        for (int k = 0; k < n; k++) begin
            item_t it;
            it.x   = k % w;
            it.rgb = bar_rgb(it.x / (w / 8));
            exp_q.push_back(it);
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && pvalid && exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            chk(px == LW'(it.x), "R7 pixel x", int'(px), it.x);
            chk(prgb == it.rgb, "R8 bar colour", int'(prgb), int'(it.rgb));
        end
    end

    task automatic drive_step();
        @(posedge clk); #1;
    endtask

    task automatic sample();
        @(negedge clk);
    endtask

    task automatic do_reset(input logic strap, input int w);
        rst = 1'b1; ded_pin = strap; line_w = LW'(w);
        evt_set = '0; evt_clr = '0;
        repeat (3) drive_step();
        sample();
        chk(!ded_oe && !shr_oe, "R2 pins released in reset", {ded_oe, shr_oe}, 0);
        chk(!tmode, "R1 no test mode during reset", tmode, 0);
    endtask

    task automatic release_rst();
        drive_step();
        rst = 1'b0;
    endtask

    task automatic run_pattern(input int w, input int n);
        do_reset(1'b0, w);
        push_line(w, n);
        release_rst();
        ded_pin = 1'b1;
        sample();
        chk(tmode, "R1 strap low gives test mode", tmode, 1);
        chk(pvalid, "R7 valid first cycle", pvalid, 1);
        while (exp_q.size() > 0) sample();
        chk(tmode, "R1 strap held after pin rises", tmode, 1);
    endtask

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; ded_pin = 1'b1; sel_clk = 1'b0; pll_clk = 1'b0;
        evt_set = '0; evt_clr = '0; evt_en = '0; line_w = LW'(16);

        do_reset(1'b1, 16);
        release_rst();
        sample();
        chk(!tmode, "R1 strap high gives normal mode", tmode, 0);
        chk(!pvalid && px == '0 && prgb == '0, "R9 idle pixels", int'(prgb), 0);
        chk(!shr_oe && !ded_oe, "R5 shared pin idle irq", shr_oe, 0);

        drive_step(); ded_pin = 1'b0;
        repeat (3) drive_step();
        sample();
        chk(!tmode, "R1 pin low after reset ignored", tmode, 0);
        chk(!pvalid, "R9 still idle", pvalid, 0);
        ded_pin = 1'b1;

        // Enabled event
        drive_step(); evt_en = 3'b001; evt_set = 3'b001;
        drive_step(); evt_set = '0;
        sample();
        chk(ded_oe, "R4 enabled flag pulls ded low", ded_oe, 1);
        chk(shr_oe && !shr_o, "R5 shared pin pulls low in irq mode", {shr_oe, shr_o}, 2);

        // Clear bit0, set disabled bit1
        drive_step(); evt_clr = 3'b001; evt_set = 3'b010;
        drive_step(); evt_clr = '0; evt_set = '0;
        sample();
        chk(!ded_oe && !shr_oe, "R4 disabled flag does not drive", ded_oe, 0);
        drive_step(); evt_en = 3'b011;
        sample();
        chk(ded_oe, "R3 flag kept while disabled", ded_oe, 1);

        // Set and clear together
        drive_step(); evt_set = 3'b010; evt_clr = 3'b010;
        drive_step(); evt_set = '0; evt_clr = '0;
        sample();
        chk(ded_oe, "R3 set wins over clear", ded_oe, 1);
        drive_step(); evt_clr = 3'b010;
        drive_step(); evt_clr = '0;
        sample();
        chk(!ded_oe && !shr_oe, "R4 release when cleared", ded_oe, 0);

        // Clock mode
        drive_step(); sel_clk = 1'b1;
        sample();
        chk(!shr_oe, "R5 select registered", shr_oe, 0);
        drive_step(); pll_clk = 1'b1;
        sample();
        chk(shr_oe && shr_o, "R5 clock high on shared pin", {shr_oe, shr_o}, 3);
        drive_step(); pll_clk = 1'b0;
        sample();
        chk(shr_oe && !shr_o, "R5 clock low on shared pin", {shr_oe, shr_o}, 2);
        chk(!ded_oe, "R6 ded idle in clock mode", ded_oe, 0);
        drive_step(); evt_set = 3'b100; evt_en = 3'b100;
        drive_step(); evt_set = '0; pll_clk = 1'b1;
        sample();
        chk(ded_oe, "R6 ded irq while clock out", ded_oe, 1);
        chk(shr_oe && shr_o, "R6 shared still clock", {shr_oe, shr_o}, 3);
        drive_step(); evt_clr = 3'b100;
        drive_step(); evt_clr = '0;
        sample();
        chk(!ded_oe, "R6 ded released", ded_oe, 0);

        // Test pattern runs; sel_clk still 1 going into reset
        do_reset(1'b0, 16);
        chk(!shr_oe, "R2 shared released in reset", shr_oe, 0);
        sel_clk = 1'b0;
        run_pattern(16, 40);
        run_pattern(64, 140);
        run_pattern(8, 20);

        do_reset(1'b1, 16);
        release_rst();
        sample();
        chk(!tmode && !pvalid, "R9 normal mode after strap high", {tmode, pvalid}, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule